// File: doc/BRIEF.md
# Critical-Word-First Line Refill Controller

This block runs the refill of one cache line after a miss. When a miss is accepted it issues a single burst request to the next memory level. The request names the line and the word at which the burst starts. As words come back, in request order, the block steers each one to its slot in the line storage. It also tracks which slots have been filled. The processor is released in the cycle after the word it asked for is captured, and the rest of the line keeps filling in the background.

Two fill orders are offered and chosen per miss. In critical-word-first order the burst starts at the requested word and wraps past the last word back to word 0. In early-restart order the burst always starts at word 0 and runs in ascending order. In both orders the processor is released as soon as its own word arrives. The line is marked valid only after the last word has been written. While the fill is running, a second access can ask through the probe port whether the word it needs has already landed.

Top module: `cwf_refill_ctrl`

## Requirements
- R1: After reset, `busy`, `cpu_stall`, `line_valid`, `mem_req_valid`, `wr_en`, `cpu_data_valid`, `fill_done` and `probe_stall` are all 0.
- R2: A `miss_valid` seen while idle is accepted at that clock edge. From the next cycle, `busy` and `cpu_stall` are 1 and `line_valid` is 0, and `mem_req_valid` is 1 for exactly that one cycle, carrying the miss line on `mem_req_line`.
- R3: With `miss_cwf`=1, `mem_req_start` equals the requested word. The k-th returned word (k from 0) is written at index (requested + k) mod WORDS.
- R4: With `miss_cwf`=0, `mem_req_start` is 0 and the k-th returned word is written at index k.
- R5: `cpu_data_valid` is 1 in exactly the one response cycle whose write index equals the requested word, and in that cycle `cpu_data` equals `mem_rsp_data`.
- R6: `cpu_stall` stays 1 through the cycle in which the requested word is captured and is 0 from the next cycle. It stays 0 while the rest of the line fills.
- R7: `fill_done` is 1 in the cycle of the WORDS-th write. `line_valid` and `busy` change (1 and 0 respectively) on the next edge, never earlier.
- R8: `probe_stall` is 1 exactly when `probe_valid` is 1, a fill is active, `probe_line` equals the line being filled, and the word at `probe_word` has not yet been written. Otherwise it is 0.
- R9: A `miss_valid` that arrives while busy is ignored: no new request, and the order and line of the fill are unchanged. A `mem_rsp_valid` that arrives while idle causes no write and no data pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | Start a refill (accepted only when idle) |
| miss_line | input | LINE_W | Line address of the miss |
| miss_word | input | IDX_W | Word the processor requested |
| miss_cwf | input | 1 | 1: critical-word-first order, 0: early-restart order |
| busy | output | 1 | Fill in progress |
| mem_req_valid | output | 1 | One-cycle burst request pulse |
| mem_req_line | output | LINE_W | Line address of the burst |
| mem_req_start | output | IDX_W | First word index of the burst |
| mem_rsp_valid | input | 1 | A returned word is present |
| mem_rsp_data | input | DATA_W | Returned word |
| wr_en | output | 1 | Write strobe to line storage |
| wr_word | output | IDX_W | Word slot being written |
| wr_data | output | DATA_W | Data being written |
| cpu_data_valid | output | 1 | Requested word delivered this cycle |
| cpu_data | output | DATA_W | Requested word |
| cpu_stall | output | 1 | Processor must wait |
| line_valid | output | 1 | Filled line is complete |
| fill_done | output | 1 | Last word written this cycle |
| probe_valid | input | 1 | A second access is checking the line |
| probe_line | input | LINE_W | Line of the second access |
| probe_word | input | IDX_W | Word the second access needs |
| probe_stall | output | 1 | Second access must wait |

## Verification
Some relations are checked by the assertions on every cycle. A request pulse lasts one cycle and only occurs during a fill. The first write lands at the burst start. The data pulse coincides with a write and ends the stall on the next edge. `line_valid` rises only after `fill_done`, and nothing is written while idle. Other behaviours only show in the bench's sweep over every requested word in both orders, with and without bubbles between responses. These are the full wrap sequence of write indices, the exact cycle of release, the probe answers as slots fill, and a rejected second miss.

// File: rtl/rfl_pkg.sv
package rfl_pkg;
   typedef enum logic {
      ORDER_SEQ = 1'b0,
      ORDER_CWF = 1'b1
   } fill_order_e;

   function automatic int idx_bits(input int n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/rfl_wrap_ctr.sv
module rfl_wrap_ctr #(
   parameter int WORDS = 8,
   localparam int IDX_W = rfl_pkg::idx_bits(WORDS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [IDX_W-1:0] load_val,
   input  logic             step,
   output logic [IDX_W-1:0] idx
);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(WORDS - 1);
   localparam bit POW2 = (WORDS == (1 << IDX_W));

   logic [IDX_W-1:0] idx_q;
   logic [IDX_W-1:0] idx_nxt;

   generate
      if (POW2) begin : g_pow2
         always_comb idx_nxt = idx_q + 1'b1;
      end else begin : g_wrap
         always_comb idx_nxt = (idx_q == LAST) ? '0 : idx_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)    idx_q <= '0;
      else if (load) idx_q <= load_val;
      else if (step) idx_q <= idx_nxt;
   end

   assign idx = idx_q;
endmodule

// File: rtl/rfl_arrival.sv
module rfl_arrival #(
   parameter int WORDS  = 8,
   parameter int LINE_W = 10,
   localparam int IDX_W = rfl_pkg::idx_bits(WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              mark,
   input  logic [IDX_W-1:0]  mark_idx,
   input  logic              active,
   input  logic [LINE_W-1:0] fill_line,
   input  logic              probe_valid,
   input  logic [LINE_W-1:0] probe_line,
   input  logic [IDX_W-1:0]  probe_word,
   output logic              probe_stall
);
   logic [WORDS-1:0] landed_q;
   logic             word_in;

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         landed_q <= '0;
      end else begin
         for (int i = 0; i < WORDS; i++) begin
            if (mark && (mark_idx == IDX_W'(i))) landed_q[i] <= 1'b1;
         end
      end
   end

   always_comb begin
      word_in = 1'b0;
      for (int i = 0; i < WORDS; i++) begin
         if (probe_word == IDX_W'(i)) word_in = landed_q[i];
      end
   end

   assign probe_stall = probe_valid && active && (probe_line == fill_line) && !word_in;
endmodule

// File: rtl/cwf_refill_ctrl.sv
module cwf_refill_ctrl #(
   parameter int WORDS  = 8,
   parameter int DATA_W = 32,
   parameter int LINE_W = 10,
   localparam int IDX_W = rfl_pkg::idx_bits(WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              miss_valid,
   input  logic [LINE_W-1:0] miss_line,
   input  logic [IDX_W-1:0]  miss_word,
   input  logic              miss_cwf,
   output logic              busy,
   output logic              mem_req_valid,
   output logic [LINE_W-1:0] mem_req_line,
   output logic [IDX_W-1:0]  mem_req_start,
   input  logic              mem_rsp_valid,
   input  logic [DATA_W-1:0] mem_rsp_data,
   output logic              wr_en,
   output logic [IDX_W-1:0]  wr_word,
   output logic [DATA_W-1:0] wr_data,
   output logic              cpu_data_valid,
   output logic [DATA_W-1:0] cpu_data,
   output logic              cpu_stall,
   output logic              line_valid,
   output logic              fill_done,
   input  logic              probe_valid,
   input  logic [LINE_W-1:0] probe_line,
   input  logic [IDX_W-1:0]  probe_word,
   output logic              probe_stall
);
   import rfl_pkg::*;

   localparam logic [IDX_W-1:0] LAST = IDX_W'(WORDS - 1);

   generate
      if (WORDS < 2) begin : g_bad_words
         $error("cwf_refill_ctrl: WORDS must be at least 2");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("cwf_refill_ctrl: DATA_W must be positive");
      end
      if (LINE_W < 1) begin : g_bad_line
         $error("cwf_refill_ctrl: LINE_W must be positive");
      end
   endgenerate

   fill_order_e      order;
   logic             accept;
   logic [IDX_W-1:0] start_word;
   logic             busy_q, req_q, stall_q, lval_q;
   logic [LINE_W-1:0] line_q;
   logic [IDX_W-1:0] crit_q, start_q, cnt_q;
   logic [IDX_W-1:0] cur_idx;
   logic             take, last_take, crit_take;

   assign order      = miss_cwf ? ORDER_CWF : ORDER_SEQ;
   assign accept     = miss_valid && !busy_q;
   assign start_word = (order == ORDER_CWF) ? miss_word : '0;

   assign take      = mem_rsp_valid && busy_q;
   assign last_take = take && (cnt_q == LAST);
   assign crit_take = take && (cur_idx == crit_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         req_q   <= 1'b0;
         stall_q <= 1'b0;
         lval_q  <= 1'b0;
         line_q  <= '0;
         crit_q  <= '0;
         start_q <= '0;
         cnt_q   <= '0;
      end else if (accept) begin
         busy_q  <= 1'b1;
         req_q   <= 1'b1;
         stall_q <= 1'b1;
         lval_q  <= 1'b0;
         line_q  <= miss_line;
         crit_q  <= miss_word;
         start_q <= start_word;
         cnt_q   <= '0;
      end else begin
         req_q <= 1'b0;
         if (crit_take) stall_q <= 1'b0;
         if (take)      cnt_q   <= cnt_q + 1'b1;
         if (last_take) begin
            busy_q <= 1'b0;
            lval_q <= 1'b1;
         end
      end
   end

   rfl_wrap_ctr #(.WORDS(WORDS)) u_idx (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept),
      .load_val (start_word),
      .step     (take),
      .idx      (cur_idx)
   );

   rfl_arrival #(.WORDS(WORDS), .LINE_W(LINE_W)) u_arr (
      .clk         (clk),
      .rst_n       (rst_n),
      .clear       (accept),
      .mark        (take),
      .mark_idx    (cur_idx),
      .active      (busy_q),
      .fill_line   (line_q),
      .probe_valid (probe_valid),
      .probe_line  (probe_line),
      .probe_word  (probe_word),
      .probe_stall (probe_stall)
   );

   assign busy           = busy_q;
   assign mem_req_valid  = req_q;
   assign mem_req_line   = line_q;
   assign mem_req_start  = start_q;
   assign wr_en          = take;
   assign wr_word        = cur_idx;
   assign wr_data        = mem_rsp_data;
   assign cpu_data_valid = crit_take;
   assign cpu_data       = mem_rsp_data;
   assign cpu_stall      = stall_q;
   assign line_valid     = lval_q;
   assign fill_done      = last_take;
endmodule

// File: rtl/cwf_refill_ctrl_chk.sv
module cwf_refill_ctrl_chk #(
   parameter int WORDS  = 8,
   parameter int DATA_W = 32,
   localparam int IDX_W = rfl_pkg::idx_bits(WORDS)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              mem_req_valid,
   input logic [IDX_W-1:0]  mem_req_start,
   input logic              mem_rsp_valid,
   input logic [DATA_W-1:0] mem_rsp_data,
   input logic              wr_en,
   input logic [IDX_W-1:0]  wr_word,
   input logic              cpu_data_valid,
   input logic [DATA_W-1:0] cpu_data,
   input logic              cpu_stall,
   input logic              line_valid,
   input logic              fill_done,
   input logic              probe_stall,
   input logic [IDX_W-1:0]  cnt_q
);
   p_req_in_fill_r2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> busy);
   p_req_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |=> !mem_req_valid);
   p_first_at_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && cnt_q == '0) |-> (wr_word == mem_req_start));
   p_crit_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_data_valid |-> (wr_en && mem_rsp_valid && cpu_data == mem_rsp_data));
   p_held_until_crit_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_data_valid |-> cpu_stall);
   p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_data_valid |=> !cpu_stall);
   p_valid_after_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(line_valid) |-> $past(fill_done));
   p_done_ends_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
      fill_done |=> (!busy && line_valid));
   p_probe_in_fill_r8: assert property (@(posedge clk) disable iff (!rst_n)
      probe_stall |-> busy);
   p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!wr_en && !cpu_data_valid && !cpu_stall));
endmodule

bind cwf_refill_ctrl cwf_refill_ctrl_chk #(.WORDS(WORDS), .DATA_W(DATA_W)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .busy           (busy),
   .mem_req_valid  (mem_req_valid),
   .mem_req_start  (mem_req_start),
   .mem_rsp_valid  (mem_rsp_valid),
   .mem_rsp_data   (mem_rsp_data),
   .wr_en          (wr_en),
   .wr_word        (wr_word),
   .cpu_data_valid (cpu_data_valid),
   .cpu_data       (cpu_data),
   .cpu_stall      (cpu_stall),
   .line_valid     (line_valid),
   .fill_done      (fill_done),
   .probe_stall    (probe_stall),
   .cnt_q          (cnt_q)
);

// File: tb/cwf_refill_ctrl_tb.sv
module cwf_refill_ctrl_tb;
   localparam int CLK_PERIOD = 10;
   localparam int WORDS  = 8;
   localparam int DATA_W = 32;
   localparam int LINE_W = 10;
   localparam int IDX_W  = 3;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              miss_valid = 1'b0;
   logic [LINE_W-1:0] miss_line = '0;
   logic [IDX_W-1:0]  miss_word = '0;
   logic              miss_cwf = 1'b0;
   logic              busy, mem_req_valid;
   logic [LINE_W-1:0] mem_req_line;
   logic [IDX_W-1:0]  mem_req_start;
   logic              mem_rsp_valid = 1'b0;
   logic [DATA_W-1:0] mem_rsp_data = '0;
   logic              wr_en;
   logic [IDX_W-1:0]  wr_word;
   logic [DATA_W-1:0] wr_data;
   logic              cpu_data_valid;
   logic [DATA_W-1:0] cpu_data;
   logic              cpu_stall, line_valid, fill_done;
   logic              probe_valid = 1'b0;
   logic [LINE_W-1:0] probe_line = '0;
   logic [IDX_W-1:0]  probe_word = '0;
   logic              probe_stall;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cwf_refill_ctrl #(.WORDS(WORDS), .DATA_W(DATA_W), .LINE_W(LINE_W)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .miss_valid(miss_valid), .miss_line(miss_line), .miss_word(miss_word), .miss_cwf(miss_cwf),
      .busy(busy), .mem_req_valid(mem_req_valid), .mem_req_line(mem_req_line),
      .mem_req_start(mem_req_start), .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
      .wr_en(wr_en), .wr_word(wr_word), .wr_data(wr_data),
      .cpu_data_valid(cpu_data_valid), .cpu_data(cpu_data), .cpu_stall(cpu_stall),
      .line_valid(line_valid), .fill_done(fill_done),
      .probe_valid(probe_valid), .probe_line(probe_line), .probe_word(probe_word),
      .probe_stall(probe_stall)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] word_data(input int line, input int idx);
      return 32'h5A00_0000 ^ (line << 8) ^ (idx * 32'h11);
   endfunction

   // One refill: requested word crit, order cwf, bubble pattern gap (0 = none)
   task automatic run_fill(input int line, input int crit, input bit cwf, input int gap,
                           input bit late_miss);
      int  start;
      bit  seen[WORDS];
      bit  got_crit;
      for (int i = 0; i < WORDS; i++) seen[i] = 0;
      got_crit = 0;
      start = cwf ? crit : 0;
      @(negedge clk);
      miss_valid = 1'b1; miss_line = LINE_W'(line); miss_word = IDX_W'(crit); miss_cwf = cwf;
      @(negedge clk);
      miss_valid = 1'b0;
      #1;
      chk("R2 busy after accept", busy, 1);
      chk("R2 stall after accept", cpu_stall, 1);
      chk("R2 line_valid cleared", line_valid, 0);
      chk("R2 request pulse", mem_req_valid, 1);
      chk("R2 request line", mem_req_line, line);
      if (cwf) chk("R3 request starts at requested word", mem_req_start, start);
      else     chk("R4 request starts at word 0", mem_req_start, 0);
      @(negedge clk);
      #1;
      chk("R2 request is one cycle", mem_req_valid, 0);
      for (int k = 0; k < WORDS; k++) begin
         int idx;
         idx = (start + k) % WORDS;
         if (gap != 0 && ((k + gap) % 3 == 0)) begin
            mem_rsp_valid = 1'b0;
            #1;
            chk("R5 no write in bubble", wr_en, 0);
            chk("R5 no data pulse in bubble", cpu_data_valid, 0);
            @(negedge clk);
         end
         mem_rsp_valid = 1'b1;
         mem_rsp_data  = word_data(line, idx);
         probe_valid   = 1'b1;
         if (k % 2 == 0) begin
            probe_line = LINE_W'(line);
            probe_word = IDX_W'((k * 3 + crit) % WORDS);
         end else begin
            probe_line = LINE_W'(line ^ 1);
            probe_word = IDX_W'(crit);
         end
         if (late_miss && k == 2) begin
            miss_valid = 1'b1; miss_line = LINE_W'(line ^ 3); miss_word = IDX_W'(crit ^ 1);
            miss_cwf = ~cwf;
         end
         #1;
         chk("R3 write strobe", wr_en, 1);
         if (cwf) chk("R3 wrapped write index", wr_word, idx);
         else     chk("R4 sequential write index", wr_word, idx);
         chk("R3 write data", wr_data, word_data(line, idx));
         chk("R5 data pulse at requested word", cpu_data_valid, (idx == crit) ? 1 : 0);
         if (idx == crit) chk("R5 delivered data", cpu_data, word_data(line, crit));
         chk("R6 stall until requested word captured", cpu_stall, got_crit ? 0 : 1);
         chk("R7 fill_done on last write only", fill_done, (k == WORDS - 1) ? 1 : 0);
         chk("R7 line not valid during fill", line_valid, 0);
         chk("R9 no extra request during fill", mem_req_valid, 0);
         if (k % 2 == 0) chk("R8 probe same line", probe_stall, seen[(k * 3 + crit) % WORDS] ? 0 : 1);
         else            chk("R8 probe other line", probe_stall, 0);
         @(negedge clk);
         miss_valid = 1'b0;
         seen[idx] = 1;
         if (idx == crit) got_crit = 1;
      end
      mem_rsp_valid = 1'b0;
      probe_line = LINE_W'(line);
      probe_word = IDX_W'(crit);
      #1;
      chk("R7 busy drops after last word", busy, 0);
      chk("R7 line valid after last word", line_valid, 1);
      chk("R6 no stall after fill", cpu_stall, 0);
      chk("R8 no probe stall when idle", probe_stall, 0);
      chk("R9 ignored miss made no request", mem_req_valid, 0);
      probe_valid = 1'b0;
      // response while idle is ignored
      @(negedge clk);
      mem_rsp_valid = 1'b1;
      mem_rsp_data  = 32'hDEAD_BEEF;
      #1;
      chk("R9 idle response no write", wr_en, 0);
      chk("R9 idle response no data pulse", cpu_data_valid, 0);
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      #1;
      chk("R9 idle response leaves line valid", line_valid, 1);
      chk("R9 idle response leaves idle", busy, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      #1;
      chk("R1 busy at reset", busy, 0);
      chk("R1 stall at reset", cpu_stall, 0);
      chk("R1 line_valid at reset", line_valid, 0);
      chk("R1 request at reset", mem_req_valid, 0);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      chk("R1 write strobe idle", wr_en, 0);
      chk("R1 data pulse idle", cpu_data_valid, 0);
      chk("R1 fill_done idle", fill_done, 0);
      chk("R1 probe idle", probe_stall, 0);
      for (int m = 0; m < 2; m++) begin
         for (int c = 0; c < WORDS; c++) begin
            for (int g = 0; g < 2; g++) begin
               run_fill(c * 4 + m * 64 + g * 128 + 5, c, m[0], g, (c == 3));
            end
         end
      end
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule